// File: doc/BRIEF.md
# Single-Port Attribute Register Interface with Colour Plane Masking

This block is the register front end of a text-mode attribute stage. One write port carries both a register index and a register data byte. An internal phase toggle decides which of the two each write is. The first write after the toggle is cleared is taken as an index. The next write is taken as data for the register that index selects. After that the toggle returns to index phase. Software can put the toggle back into index phase at any time by reading a separate status port. This lets a driver get back to a known phase without knowing what happened before.

The index byte has a second use. Its bit 5 turns the video path on. While that bit is clear, the pixel output shows the overscan colour instead of picture data. This lets software reprogram the palette registers without visible garbage on the screen. When the bit is set, each raw 4-bit pixel passes through the colour plane enable mask before it goes to palette lookup. Each bit of the mask either passes one pixel bit or forces it to zero.

Besides the mask and the overscan colour, the block keeps a small file of attribute registers as plain byte storage. It can be read back through a data read port.

Top module: `attr_port`

## Requirements
- R1: After reset the toggle is in index phase, the index byte is 0x00, the colour plane enable register (index 0x12) holds 0x0F, and every other register holds 0x00. So the first clock after reset shows dispEn = 0 and pixOut = 0.
- R2: Each write with portSel = 2'b00 (attribute port) flips the toggle. In index phase, wrData is stored as the index byte. In data phase, wrData is stored into the register selected by bits 4:0 of the index byte.
- R3: A read with portSel = 2'b10 (status port) returns the toggle state in bit 0 (1 = data phase) and zeros in bits 7:1. It puts the toggle into index phase.
- R4: A read with portSel = 2'b00 returns the whole current index byte. It leaves the toggle unchanged.
- R5: dispEn equals bit 5 of the index byte as it stood one clock earlier.
- R6: When dispEn is 1, pixOut equals pixIn from the previous clock ANDed with bits 3:0 of register 0x12 from the previous clock.
- R7: When dispEn is 0, pixOut equals bits 3:0 of the overscan register at index 0x11, taken from the previous clock. In this case pixIn has no effect.
- R8: Registers exist at indices 0x00 to 0x14. A data-phase write whose index field is 0x15 to 0x1F changes no register. It still returns the toggle to index phase.
- R9: A read with portSel = 2'b01 (data read port) returns the register selected by the index field, or 0x00 for an unimplemented index. A read with portSel = 2'b11 returns 0x00. Reads change no register.
- R10: rdData is registered: it shows the result of a read one clock after rdEn is sampled, and it holds between reads. Writes with portSel other than 2'b00 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| portSel | input | 2 | 00 attribute port, 01 data read, 10 status, 11 none |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read result |
| pixIn | input | 4 | Raw pixel value |
| pixOut | output | 4 | Masked pixel or overscan colour |
| dispEn | output | 1 | Video path enabled (index bit 5) |

## Verification
Directed sequences run first:
- an index/data pair aimed at the plane mask;
- a status read taken halfway through a pair, which shows the toggle really resets and does not simply alternate;
- a data write to an unimplemented index, checked by reading back the mask and the overscan colour.

A long random mix then interleaves the following, against a reference model of the toggle and the register file:
- attribute writes, with both index-byte bit 5 values;
- status reads at arbitrary phase;
- index and data readbacks;
- changing pixels.

Pixels seen with the video bit clear tell masking apart from overscan substitution. Pixels seen with partial masks tell a per-bit AND apart from a whole-value gate.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int ATTR_DW    = 8;
  localparam int ATTR_IDX_W = 5;

  typedef enum logic [1:0] {
    SEL_ATTR = 2'b00,
    SEL_DATA = 2'b01,
    SEL_STAT = 2'b10,
    SEL_NONE = 2'b11
  } portSel_e;

  typedef struct packed {
    logic idxWr;
    logic regWr;
    logic attrRd;
    logic dataRd;
    logic statRd;
    logic noneRd;
  } attrStrobe_t;
endpackage

// File: rtl/attr_ctrl.sv
module attr_ctrl
  import attr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  portSel,
  output attrStrobe_t stb,
  output logic        dataPhase
);
  portSel_e selDec;
  logic     attrWr;

  assign selDec = portSel_e'(portSel);
  assign attrWr = wrEn && (selDec == SEL_ATTR);

  always_comb begin
    stb        = '0;
    stb.idxWr  = attrWr && !dataPhase;
    stb.regWr  = attrWr && dataPhase;
    stb.attrRd = rdEn && (selDec == SEL_ATTR);
    stb.dataRd = rdEn && (selDec == SEL_DATA);
    stb.statRd = rdEn && (selDec == SEL_STAT);
    stb.noneRd = rdEn && (selDec == SEL_NONE);
  end

  // Phase toggle: a status read forces index phase, an attribute write flips it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dataPhase <= 1'b0;
    else if (stb.statRd) dataPhase <= 1'b0;
    else if (attrWr)     dataPhase <= !dataPhase;
  end
endmodule

// File: rtl/attr_dpath.sv
module attr_dpath
  import attr_pkg::*;
#(
  parameter int NUM_REGS  = 21,
  parameter int PLANE_IDX = 18,
  parameter int OVS_IDX   = 17,
  parameter int PLANE_RST = 15,
  parameter int PIX_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  attrStrobe_t        stb,
  input  logic               dataPhase,
  input  logic [ATTR_DW-1:0] wrData,
  output logic [ATTR_DW-1:0] rdData,
  output logic [ATTR_DW-1:0] idxByte,
  output logic [PIX_W-1:0]   planeEn,
  output logic [PIX_W-1:0]   ovsVal
);
  localparam int IDX_SPAN = 1 << ATTR_IDX_W;

  logic [ATTR_DW-1:0]    regFile [NUM_REGS];
  logic [ATTR_IDX_W-1:0] regSel;
  logic                  idxHit;
  logic [ATTR_DW-1:0]    selReg;
  logic [ATTR_DW-1:0]    rdNext;

  assign regSel = idxByte[ATTR_IDX_W-1:0];
  assign idxHit = (IDX_SPAN'(regSel) < IDX_SPAN'(NUM_REGS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          idxByte <= '0;
    else if (stb.idxWr) idxByte <= wrData;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [ATTR_DW-1:0] RST_VAL =
      (g == PLANE_IDX) ? ATTR_DW'(PLANE_RST) : '0;
    logic [ATTR_DW-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= RST_VAL;
      else if (stb.regWr && (regSel == ATTR_IDX_W'(g)))
        q <= wrData;
    end
    assign regFile[g] = q;
  end

  always_comb begin
    selReg = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (regSel == ATTR_IDX_W'(i)) selReg = regFile[i];
  end

  always_comb begin
    rdNext = '0;
    if (stb.attrRd)      rdNext = idxByte;
    else if (stb.dataRd) rdNext = idxHit ? selReg : '0;
    else if (stb.statRd) rdNext = {{(ATTR_DW-1){1'b0}}, dataPhase};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (stb.attrRd || stb.dataRd || stb.statRd || stb.noneRd)
      rdData <= rdNext;
  end

  assign planeEn = regFile[PLANE_IDX][PIX_W-1:0];
  assign ovsVal  = regFile[OVS_IDX][PIX_W-1:0];
endmodule

// File: rtl/attr_pix_mask.sv
module attr_pix_mask #(
  parameter int PIX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             videoOn,
  input  logic [PIX_W-1:0] pixIn,
  input  logic [PIX_W-1:0] planeEn,
  input  logic [PIX_W-1:0] ovsVal,
  output logic [PIX_W-1:0] pixOut,
  output logic             dispEn
);
  logic [PIX_W-1:0] masked;

  for (genvar b = 0; b < PIX_W; b++) begin : g_bit
    assign masked[b] = pixIn[b] & planeEn[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut <= '0;
      dispEn <= 1'b0;
    end else begin
      pixOut <= videoOn ? masked : ovsVal;
      dispEn <= videoOn;
    end
  end
endmodule

// File: rtl/attr_port.sv
module attr_port
  import attr_pkg::*;
#(
  parameter int NUM_REGS  = 21,
  parameter int PLANE_IDX = 18,
  parameter int OVS_IDX   = 17,
  parameter int VIDEO_BIT = 5,
  parameter int PIX_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       portSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] pixOut,
  output logic             dispEn
);
  localparam int PLANE_RST = (1 << PIX_W) - 1;

  attrStrobe_t        stb;
  logic               dataPhase;
  logic [ATTR_DW-1:0] idxByte;
  logic [PIX_W-1:0]   planeEn;
  logic [PIX_W-1:0]   ovsVal;

  attr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .portSel(portSel), .stb(stb), .dataPhase(dataPhase)
  );

  attr_dpath #(
    .NUM_REGS(NUM_REGS), .PLANE_IDX(PLANE_IDX), .OVS_IDX(OVS_IDX),
    .PLANE_RST(PLANE_RST), .PIX_W(PIX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dataPhase(dataPhase),
    .wrData(wrData), .rdData(rdData), .idxByte(idxByte),
    .planeEn(planeEn), .ovsVal(ovsVal)
  );

  attr_pix_mask #(.PIX_W(PIX_W)) u_pix (
    .clk(clk), .rstN(rstN), .videoOn(idxByte[VIDEO_BIT]),
    .pixIn(pixIn), .planeEn(planeEn), .ovsVal(ovsVal),
    .pixOut(pixOut), .dispEn(dispEn)
  );
endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk #(
  parameter int NUM_REGS  = 21,
  parameter int VIDEO_BIT = 5,
  parameter int PIX_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [1:0]       portSel,
  input logic             dataPhase,
  input logic [7:0]       idxByte,
  input logic [PIX_W-1:0] planeEn,
  input logic [PIX_W-1:0] ovsVal,
  input logic [PIX_W-1:0] pixOut,
  input logic             dispEn
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!dataPhase && planeEn == {PIX_W{1'b1}} && !dispEn));

  a_r2_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == 2'b00) |=> (dataPhase != $past(dataPhase)));

  a_r3_status_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && portSel == 2'b10) |=> !dataPhase);

  a_r4_read_keeps_phase: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && portSel == 2'b00 && !wrEn) |=> $stable(dataPhase));

  a_r5_disp_follows_bit: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (dispEn == $past(idxByte[VIDEO_BIT])));

  a_r6_masked_bits_low: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (!dispEn || ((pixOut & ~$past(planeEn)) == '0)));

  a_r7_overscan_shown: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (dispEn || (pixOut == $past(ovsVal))));

  a_r8_unimpl_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == 2'b00 && dataPhase && (32'(idxByte[4:0]) >= NUM_REGS))
      |=> ($stable(planeEn) && $stable(ovsVal)));
endmodule

bind attr_port attr_port_chk #(
  .NUM_REGS(NUM_REGS), .VIDEO_BIT(VIDEO_BIT), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .portSel(portSel),
  .dataPhase(dataPhase), .idxByte(idxByte), .planeEn(planeEn),
  .ovsVal(ovsVal), .pixOut(pixOut), .dispEn(dispEn)
);

// File: tb/attr_port_tb.sv
module attr_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] portSel = 2'b11;
  logic [7:0] wrData = '0;
  logic [3:0] pixIn = '0;
  logic [7:0] rdData;
  logic [3:0] pixOut;
  logic       dispEn;

  always #5 clk = ~clk;

  attr_port u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .portSel(portSel),
    .wrData(wrData), .rdData(rdData), .pixIn(pixIn), .pixOut(pixOut),
    .dispEn(dispEn)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model
  logic       mPhase;
  logic [7:0] mIdx;
  logic [7:0] mRegs [32];

  function automatic logic [3:0] expPix(logic [7:0] idx, logic [3:0] p,
                                        logic [7:0] plane, logic [7:0] ovs);
    return idx[5] ? (p & plane[3:0]) : ovs[3:0];
  endfunction

  function automatic logic [7:0] expRead(logic [1:0] sel);
    case (sel)
      2'b00:   return mIdx;
      2'b01:   return (mIdx[4:0] < 5'd21) ? mRegs[mIdx[4:0]] : 8'h00;
      2'b10:   return {7'b0, mPhase};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(bit w, bit r, logic [1:0] sel, logic [7:0] d,
                    logic [3:0] p, string rdTag);
    logic [7:0] eRd;
    logic [3:0] ePix;
    logic       eDisp;
    @(negedge clk);
    wrEn = w; rdEn = r; portSel = sel; wrData = d; pixIn = p;
    eDisp = mIdx[5];
    ePix  = expPix(mIdx, p, mRegs[18], mRegs[17]);
    eRd   = expRead(sel);
    if (r && sel == 2'b10) mPhase = 1'b0;
    else if (w && sel == 2'b00) begin
      if (!mPhase) mIdx = d;
      else if (mIdx[4:0] < 5'd21) mRegs[mIdx[4:0]] = d;
      mPhase = !mPhase;
    end
    @(posedge clk);
    #1;
    check("R5 dispEn", {7'b0, dispEn}, {7'b0, eDisp});
    check(eDisp ? "R6 masked pixel" : "R7 overscan pixel", {4'b0, pixOut}, {4'b0, ePix});
    if (r) check(rdTag, rdData, eRd);
    wrEn = 1'b0; rdEn = 1'b0; portSel = 2'b11;
  endtask

  task automatic attrWrite(logic [7:0] d);
    op(1'b1, 1'b0, 2'b00, d, 4'hA, "");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    mPhase = 1'b0;
    mIdx = '0;
    for (int i = 0; i < 32; i++) mRegs[i] = 8'h00;
    mRegs[18] = 8'h0F;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    // R1 reset outputs
    check("R1 reset dispEn", {7'b0, dispEn}, 8'h00);
    check("R1 reset pixOut", {4'b0, pixOut}, 8'h00);
    op(1'b0, 1'b1, 2'b10, 8'h00, 4'h3, "R1 reset phase");
    op(1'b0, 1'b1, 2'b00, 8'h00, 4'h3, "R1 reset index");
    attrWrite(8'h12);
    op(1'b0, 1'b1, 2'b01, 8'h00, 4'h3, "R1 reset plane enable");

    // R2 pair: write mask 0x05, display on
    attrWrite(8'h05);
    op(1'b0, 1'b1, 2'b10, 8'h00, 4'hF, "R2 phase back to index");
    attrWrite(8'h32);
    op(1'b0, 1'b1, 2'b01, 8'h00, 4'hF, "R2 stored plane enable");
    op(1'b0, 1'b0, 2'b11, 8'h00, 4'hF, "");
    check("R6 mask 0x5 on 0xF", {4'b0, pixOut}, 8'h05);

    // R3 status read mid-pair restarts the sequence
    attrWrite(8'h31);
    op(1'b0, 1'b1, 2'b10, 8'h00, 4'h7, "R3 status mid pair");
    op(1'b0, 1'b1, 2'b10, 8'h00, 4'h7, "R3 status after clear");
    attrWrite(8'h11);
    attrWrite(8'h09);
    op(1'b0, 1'b1, 2'b01, 8'h00, 4'h7, "R9 overscan readback");
    op(1'b0, 1'b1, 2'b00, 8'h00, 4'h7, "R4 index readback");
    op(1'b0, 1'b1, 2'b10, 8'h00, 4'h7, "R4 phase unchanged");
    op(1'b0, 1'b0, 2'b11, 8'h00, 4'h7, "");
    check("R7 overscan while off", {4'b0, pixOut}, 8'h09);

    // R8 unimplemented index
    attrWrite(8'h1B);
    attrWrite(8'hFF);
    op(1'b0, 1'b1, 2'b10, 8'h00, 4'h2, "R8 phase returns to index");
    op(1'b0, 1'b1, 2'b01, 8'h00, 4'h2, "R9 unimplemented reads zero");
    attrWrite(8'h12);
    op(1'b0, 1'b1, 2'b01, 8'h00, 4'h2, "R8 plane enable untouched");
    attrWrite(8'h0F);

    // R10 writes to other ports ignored; none read returns zero
    op(1'b1, 1'b0, 2'b10, 8'h44, 4'h2, "");
    op(1'b1, 1'b0, 2'b01, 8'h44, 4'h2, "");
    op(1'b0, 1'b1, 2'b10, 8'h00, 4'h2, "R10 foreign writes leave phase");
    op(1'b0, 1'b1, 2'b11, 8'h00, 4'h2, "R10 none read");
    op(1'b0, 1'b0, 2'b11, 8'h00, 4'h2, "");
    check("R10 rdData holds", rdData, 8'h00);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] k;
      logic [7:0] d;
      logic [1:0] s;
      k = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      s = 2'($urandom);
      if (k < 4'd7) begin
        if (!mPhase && k[0]) d[4:0] = k[1] ? 5'h12 : 5'h11;
        op(1'b1, 1'b0, 2'b00, d, 4'($urandom), "");
      end else if (k < 4'd13)
        op(1'b0, 1'b1, s, 8'h00, 4'($urandom),
           s == 2'b00 ? "R4 random index read" :
           s == 2'b01 ? "R9 random data read" :
           s == 2'b10 ? "R3 random status read" : "R10 random none read");
      else
        op(1'b0, 1'b0, 2'b11, 8'h00, 4'($urandom), "");
    end

    summary();
  end
endmodule